// File: doc/BRIEF.md
# Multichannel I2S Master Serial Port

This block is the master side of a stereo audio serial link. From a fast system clock it makes a serial bit clock and a frame clock, using a prescale count and a slots-per-frame count. It drives several transmit data lines that share that clock pair, three by default, so six audio channels leave per two-slot frame. It also samples one receive data line in the same slots. Words use I2S framing. The frame clock is low for the left half of the frame and high for the right half. Each word starts one bit clock period after the frame clock edge that opens its slot, and the most significant bit goes first.

Software or a DMA engine feeds each transmit lane through a one-word valid/ready holding stage. It takes received words from a valid/ready output. On the transmit side, a lane with a word waiting holds `tx_ready` low for that lane. A producer may keep `tx_valid` high until the word is accepted. On the receive side, the port does not stall the serial line. A word that is still waiting when the next one completes is replaced, and this is flagged as an overrun. A pulse marks every completed slot. A second pulse marks the slot that closes a frame, so buffer pointers can be realigned once per frame. Two sticky error flags, one for transmit starvation and one for receive overrun, are cleared by a clear-status strobe.

Top module: `i2s_mc_master`

## Requirements
- R1: While `en` is low, `bclk` and `fclk` rest high, every `sd_tx` line is 0, and no slot pulse is produced.
- R2: The `bclk` period is 2*(`cfg_prescale`+1) system clocks, with equal high and low times.
- R3: With S = `cfg_slots_m1`+1 slots of DATA_W bits each (S even, at least 2), one frame lasts DATA_W*S bit clocks. `fclk` is low (left) for slots 0..S/2-1 and high (right) for the rest.
- R4: `fclk` and every `sd_tx` line change only on a falling edge of `bclk` while the port runs.
- R5: Each transmit word goes out MSB first. Its MSB occupies the second bit period of its slot, and its LSB occupies the first bit period of the following slot.
- R6: Each transmit lane carries its own word stream. All lanes use the same slot timing.
- R7: A lane takes a word on a clock with `tx_valid` and `tx_ready` both high. `tx_ready` is low while a word is held. The held word moves to the shifter at the next slot start.
- R8: If a lane holds no word at a slot start, that slot sends all zeros and `err_underrun` is set and stays set.
- R9: `sd_rx` is sampled on rising `bclk` edges, with the same bit placement as R5. At the end of each slot the completed word appears on `rx_data` with `rx_valid` high. The word stays there until `rx_ready` is seen high.
- R10: If a received word completes while the previous word is still unread, the new word replaces it and `err_overrun` is set and stays set. A `stat_clr` strobe clears both error flags, and a new error event in the same cycle wins.
- R11: `slot_pulse` is high for one clock after each completed slot. `last_pulse` is high together with it only when the completed slot was the last of its frame.
- R12: After `en` rises, the first `bclk` falling edge comes on the (`cfg_prescale`+1)-th clock edge. On that edge `fclk` falls and left slot 0 begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the clocks idle |
| cfg_prescale | input | PM_W | Bit clock prescale count |
| cfg_slots_m1 | input | DC_W | Slots per frame minus one |
| tx_valid | input | NTX | Per-lane transmit word offered |
| tx_data | input | NTX*DATA_W | Per-lane transmit words, lane i at bits i*DATA_W upward |
| tx_ready | output | NTX | Per-lane holding stage empty |
| rx_valid | output | 1 | Received word available |
| rx_data | output | DATA_W | Received word |
| rx_ready | input | 1 | Consumer takes the received word |
| slot_pulse | output | 1 | One-clock pulse per completed slot |
| last_pulse | output | 1 | One-clock pulse when the completed slot closed a frame |
| stat_clr | input | 1 | Clears both sticky error flags |
| err_underrun | output | 1 | Sticky transmit starvation flag |
| err_overrun | output | 1 | Sticky receive overwrite flag |
| bclk | output | 1 | Serial bit clock |
| fclk | output | 1 | Frame clock (low = left) |
| sd_tx | output | NTX | Transmit serial data lines |
| sd_rx | input | 1 | Receive serial data line |

## Verification
The assertions assume that `cfg_prescale` and `cfg_slots_m1` change only while `en` is low. They also assume that the slot count is even and at least two, and that `sd_rx` moves only on falling bit clock edges, as a slave codec drives it. The stimulus meets these conditions. It writes both settings between runs with the port disabled. It uses two- and four-slot frames only. The bench's codec model updates `sd_rx` shortly after each falling `bclk` edge it observes.

// File: rtl/i2s_mc_pkg.sv
package i2s_mc_pkg;
  // Frame clock level: left half of the frame is low, right half high.
  typedef enum logic {LVL_LEFT = 1'b0, LVL_RIGHT = 1'b1} lr_e;

  // Slot index at or past half the slot count belongs to the right half.
  function automatic lr_e slot_level(input int unsigned slot, input int unsigned slots_m1);
    return (slot >= (slots_m1 + 1) / 2) ? LVL_RIGHT : LVL_LEFT;
  endfunction
endpackage

// File: rtl/i2s_mc_clkgen.sv
module i2s_mc_clkgen #(
  parameter int unsigned PM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PM_W-1:0] prescale,
  output logic            bclk,
  output logic            tick_fall,
  output logic            tick_rise
);
  logic [PM_W-1:0] cnt_q;
  logic            bclk_q;
  logic            tick;

  assign tick      = en && (cnt_q >= prescale);
  assign tick_fall = tick && bclk_q;
  assign tick_rise = tick && !bclk_q;
  assign bclk      = bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q  <= '0;
      bclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_mc_framer.sv
module i2s_mc_framer
  import i2s_mc_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DC_W   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DC_W-1:0] slots_m1,
  input  logic            tick_fall,
  input  logic            tick_rise,
  output logic            fclk,
  output logic            slot_start,
  output logic            word_done,
  output logic            last_done
);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [BW-1:0]   bit_q;
  logic [DC_W-1:0] slot_q;
  logic [DC_W-1:0] slot_nx;
  lr_e             lvl_q;
  logic            primed_q;

  assign slot_nx    = (slot_q >= slots_m1) ? '0 : slot_q + 1'b1;
  assign slot_start = tick_fall && (bit_q == LAST_BIT);
  assign word_done  = tick_rise && (bit_q == '0) && primed_q;
  assign last_done  = word_done && (slot_q == '0);
  assign fclk       = (lvl_q == LVL_RIGHT);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      bit_q    <= LAST_BIT;
      slot_q   <= slots_m1;
      lvl_q    <= LVL_RIGHT;
      primed_q <= 1'b0;
    end else if (tick_fall) begin
      if (bit_q == LAST_BIT) begin
        bit_q  <= '0;
        slot_q <= slot_nx;
        lvl_q  <= slot_level(int'(slot_nx), int'(slots_m1));
      end else begin
        bit_q <= bit_q + 1'b1;
      end
      if (bit_q == '0) primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2s_mc_txlane.sv
module i2s_mc_txlane #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick_fall,
  input  logic              slot_start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              sd,
  output logic              starve
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] shift_q;
  logic              full_q;
  logic              sd_q;

  assign in_ready = !full_q;
  assign sd       = sd_q;
  assign starve   = slot_start && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      full_q  <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      if (!en) begin
        sd_q <= 1'b0;
      end else if (tick_fall) begin
        // The bit leaving the top is the previous word's LSB at a slot start.
        sd_q <= shift_q[DATA_W-1];
        if (slot_start) shift_q <= full_q ? hold_q : '0;
        else            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
      end
      if (slot_start) full_q <= 1'b0;
      if (in_valid && !full_q) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2s_mc_rxlane.sv
module i2s_mc_rxlane #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd,
  input  logic              tick_rise,
  input  logic              word_done,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              clobber
);
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] word_nx;
  logic              valid_q;

  assign word_nx   = {shift_q[DATA_W-2:0], sd};
  assign out_valid = valid_q;
  assign clobber   = word_done && valid_q && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q  <= '0;
      out_data <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (tick_rise) shift_q <= word_nx;
      if (word_done) begin
        out_data <= word_nx;
        valid_q  <= 1'b1;
      end else if (valid_q && out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2s_mc_master.sv
module i2s_mc_master #(
  parameter int unsigned NTX    = 3,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned PM_W   = 8,
  parameter int unsigned DC_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [PM_W-1:0]       cfg_prescale,
  input  logic [DC_W-1:0]       cfg_slots_m1,
  input  logic [NTX-1:0]        tx_valid,
  input  logic [NTX*DATA_W-1:0] tx_data,
  output logic [NTX-1:0]        tx_ready,
  output logic                  rx_valid,
  output logic [DATA_W-1:0]     rx_data,
  input  logic                  rx_ready,
  output logic                  slot_pulse,
  output logic                  last_pulse,
  input  logic                  stat_clr,
  output logic                  err_underrun,
  output logic                  err_overrun,
  output logic                  bclk,
  output logic                  fclk,
  output logic [NTX-1:0]        sd_tx,
  input  logic                  sd_rx
);
  logic           tick_fall, tick_rise;
  logic           slot_start, word_done, last_done;
  logic [NTX-1:0] starve;
  logic           clobber;
  logic           slot_q, last_q, unf_q, ovf_q;

  i2s_mc_clkgen #(.PM_W(PM_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .en(en), .prescale(cfg_prescale),
    .bclk(bclk), .tick_fall(tick_fall), .tick_rise(tick_rise)
  );

  i2s_mc_framer #(.DATA_W(DATA_W), .DC_W(DC_W)) framer_i (
    .clk(clk), .rst_n(rst_n), .en(en), .slots_m1(cfg_slots_m1),
    .tick_fall(tick_fall), .tick_rise(tick_rise), .fclk(fclk),
    .slot_start(slot_start), .word_done(word_done), .last_done(last_done)
  );

  for (genvar g = 0; g < NTX; g++) begin : g_tx
    i2s_mc_txlane #(.DATA_W(DATA_W)) lane_i (
      .clk(clk), .rst_n(rst_n), .en(en), .tick_fall(tick_fall),
      .slot_start(slot_start), .in_valid(tx_valid[g]),
      .in_data(tx_data[g*DATA_W +: DATA_W]), .in_ready(tx_ready[g]),
      .sd(sd_tx[g]), .starve(starve[g])
    );
  end

  i2s_mc_rxlane #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sd(sd_rx), .tick_rise(tick_rise),
    .word_done(word_done), .out_valid(rx_valid), .out_data(rx_data),
    .out_ready(rx_ready), .clobber(clobber)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      last_q <= 1'b0;
      unf_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      slot_q <= word_done;
      last_q <= last_done;
      unf_q  <= (|starve) || (unf_q && !stat_clr);
      ovf_q  <= clobber   || (ovf_q && !stat_clr);
    end
  end

  assign slot_pulse   = slot_q;
  assign last_pulse   = last_q;
  assign err_underrun = unf_q;
  assign err_overrun  = ovf_q;
endmodule

// File: rtl/i2s_mc_master_chk.sv
module i2s_mc_master_chk #(
  parameter int unsigned NTX = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [NTX-1:0] tx_ready,
  input logic           rx_valid,
  input logic           rx_ready,
  input logic           slot_pulse,
  input logic           last_pulse,
  input logic           err_underrun,
  input logic           err_overrun,
  input logic           bclk,
  input logic           fclk,
  input logic [NTX-1:0] sd_tx
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (bclk && fclk && (sd_tx == '0) && !slot_pulse));

  assert_fclk_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(fclk)) |-> $fell(bclk));

  for (genvar g = 0; g < NTX; g++) begin : g_lane
    assert_sd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$stable(sd_tx[g])) |-> $fell(bclk));
    assert_hold_drains_at_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready[g]) |-> $fell(bclk));
  end

  assert_underrun_at_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_underrun) |-> $fell(bclk));

  assert_rx_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  assert_overrun_after_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(!bclk));

  assert_last_within_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    last_pulse |-> slot_pulse);
endmodule

bind i2s_mc_master i2s_mc_master_chk #(.NTX(NTX)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .slot_pulse(slot_pulse),
  .last_pulse(last_pulse), .err_underrun(err_underrun),
  .err_overrun(err_overrun), .bclk(bclk), .fclk(fclk), .sd_tx(sd_tx)
);

// File: tb/i2s_mc_master_tb_top.sv
module i2s_mc_master_tb_top;
  localparam int NTX = 3;
  localparam int DW  = 24;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] cfg_prescale = 8'd1;
  logic [4:0] cfg_slots_m1 = 5'd1;
  logic [NTX-1:0] tx_valid = '0;
  logic [NTX*DW-1:0] tx_data = '0;
  logic [NTX-1:0] tx_ready;
  logic rx_valid, rx_ready = 1'b1;
  logic [DW-1:0] rx_data;
  logic slot_pulse, last_pulse, stat_clr = 1'b0;
  logic err_underrun, err_overrun, bclk, fclk, sd_rx = 1'b0;
  logic [NTX-1:0] sd_tx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NTX-1:0] feed_en = '0;
  bit rx_check = 1;
  int tx_seq = 0, rx_seq = 0;
  int n_slot = 0, n_last = 0;

  logic [DW-1:0] q_tx[NTX][$];
  logic [DW-1:0] q_rx[$];

  logic mon_prev = 1'b1; int mon_idx = 0; bit mon_have = 0;
  logic [DW-1:0] mon_acc[NTX];
  logic cod_prev = 1'b1; int cod_idx = 0; bit cod_have = 0;
  logic [DW-1:0] cod_word = '0;

  i2s_mc_master dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_prescale(cfg_prescale),
    .cfg_slots_m1(cfg_slots_m1), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .slot_pulse(slot_pulse), .last_pulse(last_pulse),
    .stat_clr(stat_clr), .err_underrun(err_underrun), .err_overrun(err_overrun),
    .bclk(bclk), .fclk(fclk), .sd_tx(sd_tx), .sd_rx(sd_rx)
  );

  initial forever #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen_word(input int lane, input int seq);
    if (seq % 5 == 0) return 24'hFFFFFF;
    if (seq % 7 == 0) return 24'h800001;
    return DW'((lane + 1) * 32'h000A55A3 ^ (seq * 32'h0013579B));
  endfunction

  // Driver: offers one word per free lane and records it as expected output.
  initial forever begin
    @(negedge clk);
    for (int i = 0; i < NTX; i++) begin
      if (tx_valid[i]) tx_valid[i] = 1'b0;
      else if (rst_n && feed_en[i] && tx_ready[i]) begin
        logic [DW-1:0] w;
        w = gen_word(i, tx_seq);
        tx_seq++;
        tx_data[i*DW +: DW] = w;
        tx_valid[i] = 1'b1;
        q_tx[i].push_back(w);
      end
    end
  end

  // Transmit monitor: rebuilds words from the lines at rising bit clock (R5 R6 R8).
  initial forever begin
    @(posedge bclk); #1;
    if (en) begin
      if (fclk !== mon_prev) mon_idx = 0; else mon_idx = (mon_idx + 1) % DW;
      mon_prev = fclk;
      for (int i = 0; i < NTX; i++) mon_acc[i] = {mon_acc[i][DW-2:0], sd_tx[i]};
      if (mon_idx == 0) begin
        if (mon_have)
          for (int i = 0; i < NTX; i++) begin
            logic [DW-1:0] e;
            e = (q_tx[i].size() > 0) ? q_tx[i].pop_front() : '0;
            chk(mon_acc[i] == e, "R5 R6 R8 tx word", mon_acc[i], e);
          end
        mon_have = 1;
      end
    end
  end

  // Codec model: drives sd_rx after falling bit clock, I2S placement.
  initial forever begin
    @(negedge bclk); #1;
    if (en) begin
      if (fclk !== cod_prev) cod_idx = 0; else cod_idx = (cod_idx + 1) % DW;
      cod_prev = fclk;
      if (cod_idx == 0) begin
        if (cod_have) q_rx.push_back(cod_word);
        sd_rx = cod_have ? cod_word[0] : 1'b0;
      end else begin
        if (cod_idx == 1) begin
          cod_word = gen_word(7, rx_seq);
          rx_seq++;
          cod_have = 1;
        end
        sd_rx = cod_word[DW - cod_idx];
      end
    end
  end

  // Receive consumer (R9).
  initial forever begin
    @(negedge clk);
    if (rx_valid && rx_ready && rx_check) begin
      logic [DW-1:0] e;
      e = (q_rx.size() > 0) ? q_rx.pop_front() : 'x;
      chk(rx_data === e, "R9 rx word", rx_data, e);
    end
  end

  initial forever begin
    @(negedge clk);
    if (slot_pulse) n_slot++;
    if (last_pulse) n_last++;
  end

  task automatic reset_mon();
    mon_prev = 1'b1; mon_idx = 0; mon_have = 0;
    cod_prev = 1'b1; cod_idx = 0; cod_have = 0; sd_rx = 1'b0;
  endtask

  task automatic wait_slots(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!slot_pulse) @(negedge clk);
    end
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    @(negedge clk);
    chk(err_underrun == 1'b0, "R10 clear underrun", err_underrun, 0);
    chk(err_overrun == 1'b0, "R10 clear overrun", err_overrun, 0);
  endtask

  // Enable the port, then measure clock timing and slot pulses.
  task automatic run_phase(input int pm, input int dc);
    longint t0, t1, t2;
    int n;
    @(negedge clk);
    cfg_prescale = 8'(pm); cfg_slots_m1 = 5'(dc); feed_en = '1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (fclk !== 1'b0 && n < 1000);
    chk(n == pm + 1, "R12 first fall", n, pm + 1);
    @(posedge bclk); t0 = $time;
    @(negedge bclk); t1 = $time;
    @(posedge bclk); t2 = $time;
    chk((t2 - t0) / 10 == 2 * (pm + 1), "R2 bclk period", (t2 - t0) / 10, 2 * (pm + 1));
    chk((t2 - t1) / 10 == pm + 1, "R2 bclk low time", (t2 - t1) / 10, pm + 1);
    @(negedge fclk); t0 = $time;
    @(posedge fclk); t1 = $time;
    @(negedge fclk); t2 = $time;
    chk((t1 - t0) / 10 == DW * 2 * (pm + 1) * ((dc + 1) / 2), "R3 left half",
        (t1 - t0) / 10, DW * 2 * (pm + 1) * ((dc + 1) / 2));
    chk((t2 - t0) / 10 == DW * 2 * (pm + 1) * (dc + 1), "R3 frame period",
        (t2 - t0) / 10, DW * 2 * (pm + 1) * (dc + 1));
    #1; n_slot = 0; n_last = 0;
    repeat (3) @(negedge fclk);
    #1;
    chk(n_slot == 3 * (dc + 1), "R11 slot pulses", n_slot, 3 * (dc + 1));
    chk(n_last == 3, "R11 last pulses", n_last, 3);
  endtask

  task automatic end_phase();
    feed_en = '0;
    repeat (4 * DW) @(posedge bclk);
    @(negedge clk); en = 1'b0;
    reset_mon();
    repeat (20) @(negedge clk);
    chk(bclk == 1'b1 && fclk == 1'b1, "R1 idle clocks", {bclk, fclk}, 2'b11);
    chk(sd_tx == '0, "R1 idle data", sd_tx, 0);
  endtask

  initial begin
    for (int i = 0; i < NTX; i++) mon_acc[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bclk == 1'b1 && fclk == 1'b1, "R1 reset clocks", {bclk, fclk}, 2'b11);
    chk(sd_tx == '0, "R1 reset data", sd_tx, 0);
    chk(rx_valid == 1'b0 && !err_underrun && !err_overrun, "R1 reset status",
        {rx_valid, err_underrun, err_overrun}, 0);
    chk(tx_ready == '1, "R7 reset ready", tx_ready, 3'b111);
    @(negedge clk);
    feed_en = '1;
    repeat (3) @(negedge clk);
    chk(tx_ready == '0, "R7 held word lowers ready", tx_ready, 0);

    // Two-slot frames, fast bit clock.
    run_phase(1, 1);
    end_phase();
    clear_status();

    // Four-slot frames, then starve lane 2 and stall the receiver.
    run_phase(2, 3);
    feed_en = 3'b011;
    wait_slots(3);
    chk(err_underrun == 1'b1, "R8 underrun flag", err_underrun, 1);
    rx_check = 0; rx_ready = 1'b0;
    wait_slots(3);
    chk(err_overrun == 1'b1, "R10 overrun flag", err_overrun, 1);
    chk(rx_valid == 1'b1, "R9 word held while not ready", rx_valid, 1);
    end_phase();
    @(negedge clk); rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    q_rx.delete();
    rx_check = 1;
    clear_status();

    // Slowest-to-fastest: prescale zero.
    run_phase(0, 1);
    end_phase();
    clear_status();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule